// File: doc/BRIEF.md
# Four-Channel DMA Engine with Dynamic-Memory Refresh

This block moves data between I/O devices and memory without help from the processor. Three device channels each hold a 20-bit memory address, a 16-bit transfer count and a direction bit. When an enabled channel sees its request line high, the engine asks the processor for the bus with a hold request. It waits for the hold acknowledge, runs one fly-by transfer and then gives the bus back. During the transfer it drives the memory address, the channel acknowledge and a matched pair of memory and I/O strobes.

A fourth channel keeps dynamic memory alive. An internal 16-bit down-counter, reloaded from a programmable period, raises a sticky refresh request each time it expires. The engine answers that request with a dummy memory read that is one clock shorter than a device transfer and captures no data. A refresh row pointer advances after each refresh, so successive refreshes sweep consecutive rows. All programming goes through a single write strobe that carries a channel number, a one-bit field select and a 20-bit data word.

Top module: `dma_refresh_ctrl`

## Requirements
- R1: After a synchronous reset, `hold_req`, `dack`, `tc`, `refresh_active` and all four strobes are low and `mem_addr` is zero. All device channels are disabled and the refresh timer is stopped.
- R2: A write with `wr_chan` = 0..2 and `wr_field` = 0 loads that channel's address from `wr_data[19:0]`. With `wr_field` = 1 it loads the count from `wr_data[15:0]` and the direction from `wr_data[16]`, enables the channel and clears its `tc`. With `wr_chan` = 3, `wr_field` = 0 loads the refresh row and `wr_field` = 1 loads the refresh period from `wr_data[15:0]`. A period of 0 stops the timer.
- R3: No acknowledge, `refresh_active` or strobe is driven unless `hold_req` is high. `hold_req` rises before a transfer, no transfer starts until `hold_ack` is seen high, and `hold_req` falls for at least one clock after each single transfer.
- R4: A device transfer holds its `dack` bit high for exactly 5 clocks when `rdy` stays high, and `mem_addr` shows the channel address for that whole time. The strobes are high in clocks 2 to 4. Direction 1 (I/O to memory) drives `io_rd` and `mem_wr`; direction 0 drives `mem_rd` and `io_wr`.
- R5: `rdy` is sampled in the third clock of a device transfer. Each clock in which it is low holds the transfer in that clock, which lengthens both `dack` and the strobes by one clock.
- R6: After each transfer the channel address increments with wrap at 20 bits and the count decrements. A programmed count N gives N+1 transfers. The last transfer sets `tc` for that channel and disables it, and further requests on that channel are then ignored.
- R7: With a nonzero period P the refresh timer expires every P+1 clocks. The request stays pending until a refresh cycle completes, and several expiries while it is pending merge into a single refresh.
- R8: A refresh cycle holds `refresh_active` high for exactly 4 clocks and `mem_addr` shows the refresh row. `mem_rd` is high in clocks 2 and 3, no `dack`, `mem_wr`, `io_rd` or `io_wr` is driven, and `rdy` is ignored.
- R9: The refresh row increments by one after each refresh and wraps at 20 bits.
- R10: The winner is chosen when `hold_ack` is seen. A pending refresh wins over every device channel, and among device channels the lowest index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_chan | input | 2 | Target channel; 3 selects the refresh channel |
| wr_field | input | 1 | 0 = address/row, 1 = count+direction or period |
| wr_data | input | 20 | Write data |
| dreq | input | 3 | Device channel request lines |
| rdy | input | 1 | Ready; low inserts wait clocks in device transfers |
| hold_ack | input | 1 | Bus granted by the processor |
| hold_req | output | 1 | Bus request to the processor |
| dack | output | 3 | Device channel acknowledge |
| tc | output | 3 | Terminal count flags, one per device channel |
| refresh_active | output | 1 | High during a refresh cycle |
| mem_addr | output | 20 | Memory address during a cycle, zero otherwise |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |

## Verification
The bench sweeps every device channel over counts 0 to 3 from base addresses just below the 20-bit top. A design that wraps at the wrong width or gets the N+1 transfer count off by one shows the wrong addresses or the wrong number of acknowledges. It holds `rdy` low for zero to three clocks of a transfer to prove that each wait clock extends the transfer by exactly one clock; a design that samples ready in the wrong clock or lets it act on refresh gets the lengths wrong. Refresh runs at several periods, with the row starting just below the wrap. This catches an off-by-one in the reload and a refresh that takes five clocks. In a final contention case the hold acknowledge is withheld while every request and a refresh are pending. A design with wrong priority, a non-sticky refresh request or merged expiries counted twice gives the wrong grant order or the wrong number of refreshes.

// File: rtl/dmr_pkg.sv
package dmr_pkg;

    localparam int ADDR_BITS = 20;
    localparam int CNT_BITS  = 16;
    localparam int DEV_CHANS = 3;

    // Phase numbering inside a bus cycle (phase 0 = first clock)
    localparam logic [2:0] PH_WAIT      = 3'd2;
    localparam logic [2:0] PH_LAST_XFER = 3'd4;
    localparam logic [2:0] PH_LAST_REF  = 3'd3;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_HOLD,
        SQ_XFER
    } sq_state_t;

    localparam logic FLD_ADDR = 1'b0;
    localparam logic FLD_CTRL = 1'b1;

    function automatic logic [2:0] last_phase(input logic is_ref);
        return is_ref ? PH_LAST_REF : PH_LAST_XFER;
    endfunction

    function automatic logic in_strobe(input logic [2:0] ph, input logic is_ref);
        return (ph != 3'd0) && (ph < last_phase(is_ref));
    endfunction

endpackage

// File: rtl/dmr_dev_chan.sv
module dmr_dev_chan #(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_addr,
    input  logic              ld_ctrl,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              dir,
    output logic              en,
    output logic              tc
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic              dir;
        logic              en;
        logic              tc;
    } chan_state_t;

    chan_state_t cs;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs <= '0;
        end else begin
            if (ld_addr) begin
                cs.addr <= wr_data;
            end else if (step) begin
                cs.addr <= cs.addr + 1'b1;
            end
            if (ld_ctrl) begin
                cs.cnt <= wr_data[CNT_W-1:0];
                cs.dir <= wr_data[CNT_W];
                cs.en  <= 1'b1;
                cs.tc  <= 1'b0;
            end else if (step) begin
                if (cs.cnt == '0) begin
                    cs.tc <= 1'b1;
                    cs.en <= 1'b0;
                end else begin
                    cs.cnt <= cs.cnt - 1'b1;
                end
            end
        end
    end

    assign addr = cs.addr;
    assign dir  = cs.dir;
    assign en   = cs.en;
    assign tc   = cs.tc;

    AST_LAST_STEP_STOPS: assert property (@(posedge clk) disable iff (rst)
        (step && !ld_ctrl && cs.cnt == '0) |=> (tc && !en)); // R6
    AST_ADDR_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (step && !ld_addr) |=> (addr == $past(addr) + 1'b1)); // R6
    AST_TC_ONLY_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        tc |-> !en); // R6

endmodule

// File: rtl/dmr_refresh_unit.sv
module dmr_refresh_unit #(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_row,
    input  logic              ld_period,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              done,
    output logic              pend,
    output logic [ADDR_W-1:0] row
);

    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] cnt;
    logic             expire;

    assign expire = !ld_period && (period != '0) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            period <= '0;
            cnt    <= '0;
        end else if (ld_period) begin
            period <= wr_data[CNT_W-1:0];
            cnt    <= wr_data[CNT_W-1:0];
        end else if (period != '0) begin
            cnt <= (cnt == '0) ? period : cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else if (expire) begin
            pend <= 1'b1;
        end else if (done) begin
            pend <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row <= '0;
        end else if (ld_row) begin
            row <= wr_data;
        end else if (done) begin
            row <= row + 1'b1;
        end
    end

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        (pend && !done) |=> pend); // R7
    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
        (period != '0) |-> (cnt <= period)); // R7
    AST_ROW_STEPS: assert property (@(posedge clk) disable iff (rst)
        (done && !ld_row) |=> (row == $past(row) + 1'b1)); // R9

endmodule

// File: rtl/dmr_arbiter.sv
module dmr_arbiter #(
    parameter int NDEV  = 3,
    parameter int IDX_W = 2
) (
    input  logic             ref_req,
    input  logic [NDEV-1:0]  dev_req,
    output logic             any,
    output logic             pick_ref,
    output logic [IDX_W-1:0] pick_idx
);

    always_comb begin
        pick_idx = '0;
        for (int i = NDEV - 1; i >= 0; i--) begin
            if (dev_req[i]) begin
                pick_idx = IDX_W'(i);
            end
        end
        pick_ref = ref_req;
        any      = ref_req || (|dev_req);
    end

endmodule

// File: rtl/dma_refresh_ctrl.sv
module dma_refresh_ctrl
    import dmr_pkg::*;
#(
    parameter int NDEV   = DEV_CHANS,
    parameter int ADDR_W = ADDR_BITS,
    parameter int CNT_W  = CNT_BITS,
    localparam int SEL_W = $clog2(NDEV + 1),
    localparam int IDX_W = (NDEV > 1) ? $clog2(NDEV) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_chan,
    input  logic              wr_field,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [NDEV-1:0]   dreq,
    input  logic              rdy,
    input  logic              hold_ack,
    output logic              hold_req,
    output logic [NDEV-1:0]   dack,
    output logic [NDEV-1:0]   tc,
    output logic              refresh_active,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              io_rd,
    output logic              io_wr
);

    typedef struct packed {
        sq_state_t        st;
        logic [2:0]       phase;
        logic             is_ref;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t sq, sq_nx;

    logic [ADDR_W-1:0] ch_addr [NDEV];
    logic [NDEV-1:0]   ch_dir, ch_en, ch_step, ld_a, ld_c;
    logic              ref_pend, ref_done, ld_row, ld_period;
    logic [ADDR_W-1:0] ref_row;
    logic              any_req, pick_ref;
    logic [IDX_W-1:0]  pick_idx;
    logic              in_xfer, xfer_last, strb;
    logic [ADDR_W-1:0] sel_addr;
    logic              sel_dir;

    // Channel datapaths
    for (genvar g = 0; g < NDEV; g++) begin : g_chan
        assign ld_a[g]    = wr_en && (wr_chan == SEL_W'(g)) && (wr_field == FLD_ADDR);
        assign ld_c[g]    = wr_en && (wr_chan == SEL_W'(g)) && (wr_field == FLD_CTRL);
        assign dack[g]    = in_xfer && !sq.is_ref && (sq.idx == IDX_W'(g));
        assign ch_step[g] = dack[g] && xfer_last;

        dmr_dev_chan #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W)
        ) u_chan (
            .clk     (clk),
            .rst     (rst),
            .ld_addr (ld_a[g]),
            .ld_ctrl (ld_c[g]),
            .wr_data (wr_data),
            .step    (ch_step[g]),
            .addr    (ch_addr[g]),
            .dir     (ch_dir[g]),
            .en      (ch_en[g]),
            .tc      (tc[g])
        );
    end

    assign ld_row    = wr_en && (wr_chan == SEL_W'(NDEV)) && (wr_field == FLD_ADDR);
    assign ld_period = wr_en && (wr_chan == SEL_W'(NDEV)) && (wr_field == FLD_CTRL);

    dmr_refresh_unit #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_refresh (
        .clk       (clk),
        .rst       (rst),
        .ld_row    (ld_row),
        .ld_period (ld_period),
        .wr_data   (wr_data),
        .done      (ref_done),
        .pend      (ref_pend),
        .row       (ref_row)
    );

    dmr_arbiter #(
        .NDEV  (NDEV),
        .IDX_W (IDX_W)
    ) u_arb (
        .ref_req  (ref_pend),
        .dev_req  (dreq & ch_en),
        .any      (any_req),
        .pick_ref (pick_ref),
        .pick_idx (pick_idx)
    );

    // Bus cycle sequencer
    assign in_xfer   = (sq.st == SQ_XFER);
    assign xfer_last = in_xfer && (sq.phase == last_phase(sq.is_ref));

    always_comb begin
        sq_nx = sq;
        case (sq.st)
            SQ_IDLE: begin
                if (any_req) sq_nx.st = SQ_HOLD;
            end
            SQ_HOLD: begin
                if (hold_ack) begin
                    if (any_req) begin
                        sq_nx.st     = SQ_XFER;
                        sq_nx.phase  = 3'd0;
                        sq_nx.is_ref = pick_ref;
                        sq_nx.idx    = pick_idx;
                    end else begin
                        sq_nx.st = SQ_IDLE;
                    end
                end
            end
            SQ_XFER: begin
                if (xfer_last) begin
                    sq_nx.st    = SQ_IDLE;
                    sq_nx.phase = 3'd0;
                end else if (!sq.is_ref && sq.phase == PH_WAIT && !rdy) begin
                    sq_nx.phase = sq.phase;
                end else begin
                    sq_nx.phase = sq.phase + 3'd1;
                end
            end
            default: sq_nx.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sq <= '{st: SQ_IDLE, phase: 3'd0, is_ref: 1'b0, idx: '0};
        end else begin
            sq <= sq_nx;
        end
    end

    // Output decode
    always_comb begin
        sel_addr = '0;
        sel_dir  = 1'b0;
        for (int i = 0; i < NDEV; i++) begin
            if (sq.idx == IDX_W'(i)) begin
                sel_addr = ch_addr[i];
                sel_dir  = ch_dir[i];
            end
        end
    end

    assign strb           = in_xfer && in_strobe(sq.phase, sq.is_ref);
    assign refresh_active = in_xfer && sq.is_ref;
    assign ref_done       = refresh_active && xfer_last;
    assign hold_req       = (sq.st != SQ_IDLE);
    assign mem_addr       = !in_xfer ? '0 : (sq.is_ref ? ref_row : sel_addr);
    assign mem_rd         = strb && (sq.is_ref || !sel_dir);
    assign mem_wr         = strb && !sq.is_ref && sel_dir;
    assign io_rd          = strb && !sq.is_ref && sel_dir;
    assign io_wr          = strb && !sq.is_ref && !sel_dir;

    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (rst)
        $onehot0({refresh_active, dack})); // R4
    AST_BUS_NEEDS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (refresh_active || (|dack) || mem_rd || mem_wr || io_rd || io_wr) |-> hold_req); // R3
    AST_HOLD_RELEASED: assert property (@(posedge clk) disable iff (rst)
        xfer_last |=> !hold_req); // R3
    AST_NO_GRANT_EARLY: assert property (@(posedge clk) disable iff (rst)
        (sq.st == SQ_HOLD && !hold_ack) |=> (dack == '0 && !refresh_active)); // R3
    AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (rst)
        ((|dack) && $past(|dack)) |-> $stable(mem_addr)); // R4
    AST_REF_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        refresh_active |-> (!mem_wr && !io_rd && !io_wr)); // R8
    AST_REF_FIRST: assert property (@(posedge clk) disable iff (rst)
        (sq.st == SQ_HOLD && hold_ack && ref_pend) |=> refresh_active); // R10
    AST_STROBE_PAIRS: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr) && !(io_rd && io_wr)); // R4

endmodule

// File: tb/dma_refresh_ctrl_test.sv
`timescale 1ns/1ps
module dma_refresh_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_chan = '0;
    logic        wr_field = 1'b0;
    logic [19:0] wr_data = '0;
    logic [2:0]  dreq = '0;
    logic        rdy = 1'b1;
    logic        hold_ack = 1'b0;
    logic        hold_req;
    logic [2:0]  dack;
    logic [2:0]  tc;
    logic        refresh_active;
    logic [19:0] mem_addr;
    logic        mem_rd, mem_wr, io_rd, io_wr;

    dma_refresh_ctrl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_chan(wr_chan), .wr_field(wr_field),
        .wr_data(wr_data), .dreq(dreq), .rdy(rdy), .hold_ack(hold_ack),
        .hold_req(hold_req), .dack(dack), .tc(tc), .refresh_active(refresh_active),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr)
    );

    always #2 clk = ~clk;

    int vectors = 0;
    int fails = 0;
    bit ack_block = 1'b0;
    bit done_flag = 1'b0;

    // Processor model: grants the bus one half-clock after the request
    always @(negedge clk) hold_ack = hold_req && !ack_block && !rst;

    // Event monitor
    int cyc = 0;
    int ev_n = 0;
    int ev_who [64];
    int ev_addr[64];
    int ev_len [64];
    int ev_t   [64];
    int ev_mr  [64];
    int ev_mw  [64];
    int ev_ir  [64];
    int ev_iw  [64];
    int no_hold = 0;
    bit pbusy = 1'b0;

    always @(negedge clk) begin
        bit busy;
        int who;
        cyc++;
        busy = refresh_active || (|dack);
        who = 3;
        for (int i = 0; i < 3; i++) if (dack[i]) who = i;
        if (busy && !hold_req) no_hold++;
        if (busy && !pbusy && ev_n < 64) begin
            ev_who[ev_n] = who;
            ev_addr[ev_n] = int'(mem_addr);
            ev_len[ev_n] = 0;
            ev_t[ev_n] = cyc;
            ev_mr[ev_n] = 0; ev_mw[ev_n] = 0; ev_ir[ev_n] = 0; ev_iw[ev_n] = 0;
            ev_n++;
        end
        if (busy && ev_n > 0) begin
            ev_len[ev_n-1]++;
            ev_mr[ev_n-1] += int'(mem_rd);
            ev_mw[ev_n-1] += int'(mem_wr);
            ev_ir[ev_n-1] += int'(io_rd);
            ev_iw[ev_n-1] += int'(io_wr);
        end
        pbusy = busy;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int ch, input bit fld, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_chan = 2'(ch); wr_field = fld; wr_data = 20'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int b;
        int exp_row;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1", "hold_req", int'(hold_req), 0);
        chk("R1", "dack", int'(dack), 0);
        chk("R1", "tc", int'(tc), 0);
        chk("R1", "refresh_active", int'(refresh_active), 0);
        chk("R1", "strobes", int'({mem_rd, mem_wr, io_rd, io_wr}), 0);
        chk("R1", "mem_addr", int'(mem_addr), 0);
        dreq = 3'b111;
        repeat (20) @(negedge clk);
        chk("R1", "disabled channels ignore requests", int'(hold_req) + ev_n, 0);
        dreq = 3'b000;

        // R2 R4 R6: sweep channels and counts near the 20-bit wrap
        for (int c = 0; c < 3; c++) begin
            for (int n = 0; n < 4; n++) begin
                int base;
                int dir;
                base = 'hFFFFE - c;
                dir = (c + n) % 2;
                wr(c, 0, base);
                wr(c, 1, (dir << 16) | n);
                chk("R2", "tc cleared by count write", int'(tc[c]), 0);
                b = ev_n;
                dreq[c] = 1'b1;
                for (int k = 0; k < 400 && !tc[c]; k++) @(negedge clk);
                repeat (30) @(negedge clk);
                dreq[c] = 1'b0;
                chk("R6", "transfer count N+1", ev_n - b, n + 1);
                chk("R6", "tc set at end", int'(tc[c]), 1);
                for (int k = 0; k < n + 1; k++) begin
                    chk("R10", "owner", ev_who[b+k], c);
                    chk("R6", "address", ev_addr[b+k], (base + k) & 'hFFFFF);
                    chk("R4", "dack length", ev_len[b+k], 5);
                    chk("R4", "mem_rd clocks", ev_mr[b+k], dir ? 0 : 3);
                    chk("R4", "io_wr clocks", ev_iw[b+k], dir ? 0 : 3);
                    chk("R4", "mem_wr clocks", ev_mw[b+k], dir ? 3 : 0);
                    chk("R4", "io_rd clocks", ev_ir[b+k], dir ? 3 : 0);
                end
            end
        end

        // R5: wait states on channel 1
        for (int j = 3; j < 7; j++) begin
            wr(1, 0, 'h1234 + j);
            wr(1, 1, 0);
            rdy = 1'b0;
            b = ev_n;
            dreq[1] = 1'b1;
            for (int k = 0; k < 100 && !dack[1]; k++) @(negedge clk);
            repeat (j - 1) @(negedge clk);
            rdy = 1'b1;
            repeat (20) @(negedge clk);
            dreq[1] = 1'b0;
            chk("R5", "one transfer", ev_n - b, 1);
            chk("R5", "length with waits", ev_len[b], j + 2);
            chk("R5", "mem_rd clocks with waits", ev_mr[b], j);
            chk("R5", "io_wr clocks with waits", ev_iw[b], j);
        end

        // R7 R8 R9: refresh at several periods, row starting below the wrap
        exp_row = 'hFFFFE;
        wr(3, 0, exp_row);
        for (int pi = 0; pi < 3; pi++) begin
            int p;
            p = (pi == 0) ? 8 : ((pi == 1) ? 12 : 20);
            rdy = (pi != 1);
            b = ev_n;
            wr(3, 1, p);
            for (int k = 0; k < 400 && (ev_n - b) < 3; k++) @(negedge clk);
            wr(3, 1, 0);
            repeat (40) @(negedge clk);
            rdy = 1'b1;
            chk("R7", "refresh count", ev_n - b, 3);
            for (int k = 0; k < 3; k++) begin
                chk("R8", "refresh owner", ev_who[b+k], 3);
                chk("R8", "refresh length", ev_len[b+k], 4);
                chk("R8", "refresh mem_rd clocks", ev_mr[b+k], 2);
                chk("R8", "refresh other strobes", ev_mw[b+k] + ev_ir[b+k] + ev_iw[b+k], 0);
                chk("R9", "refresh row", ev_addr[b+k], exp_row);
                exp_row = (exp_row + 1) & 'hFFFFF;
                if (k > 0) chk("R7", "refresh interval", ev_t[b+k] - ev_t[b+k-1], p + 1);
            end
        end

        // R10 R3 R7: contention while the bus is withheld
        for (int c = 0; c < 3; c++) begin
            wr(c, 0, 'h500 * (c + 1));
            wr(c, 1, 0);
        end
        ack_block = 1'b1;
        b = ev_n;
        wr(3, 1, 3);
        dreq = 3'b111;
        repeat (16) @(negedge clk);
        chk("R3", "hold_req while waiting", int'(hold_req), 1);
        chk("R3", "no cycle before grant", ev_n - b, 0);
        wr(3, 1, 0);
        ack_block = 1'b0;
        repeat (60) @(negedge clk);
        dreq = 3'b000;
        chk("R7", "merged expiries plus three devices", ev_n - b, 4);
        chk("R10", "first owner is refresh", ev_who[b], 3);
        chk("R9", "refresh row continues", ev_addr[b], exp_row);
        chk("R10", "second owner", ev_who[b+1], 0);
        chk("R10", "third owner", ev_who[b+2], 1);
        chk("R10", "fourth owner", ev_who[b+3], 2);
        chk("R3", "gap between transfers", int'(ev_t[b+1] - ev_t[b] > ev_len[b]), 1);
        chk("R3", "cycles without hold_req", no_hold, 0);
        chk("R1", "idle address", int'(mem_addr), 0);

        finish_run();
    end

endmodule